// File: doc/BRIEF.md
# Vertical Polyphase Line Filter

This block filters an image along its columns even though pixels arrive one row at a time, one pixel per cycle. It keeps the three rows received before the current one in a rotating set of line stores. Each pixel of the current row is joined with the three stored pixels directly above it. The resulting four-sample column then goes through a 4-tap filter whose coefficient set is chosen from 8 phases. The outputs are rounded down and clipped to the signed pixel range, which covers −1.0 up to one step below +1.0.

A per-frame row accumulator picks the phase for each output row and decides which input rows produce an output row. This lets the same hardware filter at 1:1 or reduce the image height by any step from 1× down to below 0.25×. Pixels are signed two's complement, 10 bits by default. Line width, vertical step, start phase and frame height are sampled on the start-of-frame pixel only.

Top module: `vpf_vert_filter`

## Requirements
- R1: While reset is asserted and on the cycle after it is released, outValid, outEol and outEof are all low.
- R2: The output for an accepted input pixel appears exactly two clock cycles after the edge that accepts it, one pixel per cycle, in input order.
- R3: Rows 0, 1 and 2 of a frame never produce output. A start-of-frame pixel restarts the row count at 0. Pixels received before the first start-of-frame after reset are ignored.
- R4: For input row r ≥ 3, column c and phase p, the sum is −4·x[r−3][c] + (72−8p)·x[r−2][c] + 8p·x[r−1][c] − 4·x[r][c]. The output is this sum shifted right by 6 with rounding toward minus infinity.
- R5: Results above +511 become +511 and results below −512 become −512.
- R6: A row accumulator A is loaded with the start phase (0..7) on start-of-frame. At the first pixel of each row r ≥ 3: if A < 8, the row is emitted with phase A and A becomes A + step − 8. Otherwise the row is skipped and A becomes A − 8. The step is counted in eighths of a row.
- R7: A configured step below 8 behaves as a step of 8.
- R8: Only columns 0 to W−1 of each row are used, counted from the start-of-line pixel. Further pixels in the row are ignored and produce no output. A configured width of 0 or above 1280 is treated as 1280.
- R9: outEol is high on the output for column W−1. outEof is high on the column W−1 output of input row H−1, where H is the configured frame height.
- R10: Configuration inputs are used only when the start-of-frame pixel is accepted. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input pixel present this cycle |
| inSof | input | 1 | Pixel is the first of a frame (also starts a row) |
| inSol | input | 1 | Pixel is the first of a row |
| inPix | input | DW | Signed input pixel |
| cfgWidth | input | 11 | Active pixels per row |
| cfgStep | input | 6 | Vertical step in eighths of a row |
| cfgStartPhase | input | 3 | Accumulator value at frame start |
| cfgRows | input | RW | Input rows per frame, used for outEof |
| outValid | output | 1 | Output pixel present |
| outPix | output | DW | Saturated filtered pixel |
| outEol | output | 1 | Last pixel of an output row |
| outEof | output | 1 | Last pixel of the frame's final input row |

## Verification
Every filtered pixel is due exactly two cycles after the edge that accepts its input: one register stage reads the line stores and a second holds the saturated result. The bench drives inputs on the falling edge and records the cycle count at that moment. Each expected value, row end flag and frame end flag is queued with that count plus two. A monitor on the falling edge pops one entry per valid output and compares the arrival cycle as well as the value. Skipped rows, the first three rows and pixels beyond the width add nothing to the queue, so any output for them shows up as an unexpected arrival. An empty-queue check after each frame catches outputs that never arrive.

// File: rtl/vpf_pkg.sv
package vpf_pkg;

  localparam int COEF_W     = 8;
  localparam int COEF_SHIFT = 6;
  localparam int NUM_BANKS  = 3;

  typedef struct packed {
    logic       wrEn;
    logic [1:0] bank;
    logic       emit;
    logic [2:0] phase;
    logic       eol;
    logic       eof;
  } vpfStrobe_t;

  // weight for tap 0 (oldest row) .. tap 3 (current row), DC gain of 64
  function automatic logic signed [COEF_W-1:0] tapCoef(input logic [2:0] ph, input int tap);
    int v;
    case (tap)
      1:       v = 72 - 8 * int'(ph);
      2:       v = 8 * int'(ph);
      default: v = -4;
    endcase
    return COEF_W'(v);
  endfunction

endpackage

// File: rtl/vpf_ctrl.sv
module vpf_ctrl
  import vpf_pkg::*;
#(
  parameter int MAXW   = 1280,
  parameter int RW     = 11,
  parameter int STEP_W = 6,
  localparam int AW = $clog2(MAXW),
  localparam int WW = $clog2(MAXW + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inSof,
  input  logic              inSol,
  input  logic [WW-1:0]     cfgWidth,
  input  logic [STEP_W-1:0] cfgStep,
  input  logic [2:0]        cfgStartPhase,
  input  logic [RW-1:0]     cfgRows,
  output vpfStrobe_t        stb,
  output logic [AW-1:0]     wrAddr
);

  logic              active;
  logic [WW-1:0]     widthReg, col;
  logic [STEP_W-1:0] stepReg, acc;
  logic [RW-1:0]     rowsReg, rowIdx;
  logic [1:0]        wp;
  logic              rowEmit;
  logic [2:0]        rowPhase;

  logic              sofHit, solHit, rowStart, eligible, emitNow, act, eolNow;
  logic [RW-1:0]     nextRow, rowsNow;
  logic [WW-1:0]     colNow, widthNow;
  logic [STEP_W-1:0] stepNow, accBase, accNext;
  logic [1:0]        wpNow;
  logic [2:0]        phaseNow;

  assign sofHit   = inValid && inSof;
  assign solHit   = inValid && inSol && !inSof && active;
  assign rowStart = sofHit || solHit;

  assign widthNow = sofHit ? (((cfgWidth == '0) || (cfgWidth > WW'(MAXW))) ? WW'(MAXW) : cfgWidth)
                           : widthReg;
  assign stepNow  = sofHit ? ((cfgStep < STEP_W'(8)) ? STEP_W'(8) : cfgStep) : stepReg;
  assign rowsNow  = sofHit ? cfgRows : rowsReg;

  assign nextRow  = sofHit ? '0 : (solHit ? ((rowIdx == '1) ? rowIdx : rowIdx + 1'b1) : rowIdx);
  assign colNow   = rowStart ? '0 : col;
  assign wpNow    = sofHit ? 2'd0 : (solHit ? ((wp == 2'd2) ? 2'd0 : wp + 2'd1) : wp);
  assign accBase  = sofHit ? STEP_W'(cfgStartPhase) : acc;
  assign eligible = nextRow >= RW'(3);

  always_comb begin
    emitNow  = rowEmit;
    phaseNow = rowPhase;
    accNext  = acc;
    if (rowStart) begin
      phaseNow = accBase[2:0];
      emitNow  = eligible && (accBase < STEP_W'(8));
      if (!eligible)    accNext = accBase;
      else if (emitNow) accNext = accBase + stepNow - STEP_W'(8);
      else              accNext = accBase - STEP_W'(8);
    end
  end

  assign act    = inValid && (active || sofHit) && (colNow < widthNow);
  assign eolNow = colNow == (widthNow - 1'b1);

  assign stb.wrEn  = act;
  assign stb.bank  = wpNow;
  assign stb.emit  = act && emitNow;
  assign stb.phase = phaseNow;
  assign stb.eol   = eolNow;
  assign stb.eof   = eolNow && (nextRow == rowsNow - 1'b1);
  assign wrAddr    = colNow[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      widthReg <= WW'(MAXW);
      stepReg  <= STEP_W'(8);
      rowsReg  <= '0;
      rowIdx   <= '0;
      col      <= '0;
      wp       <= 2'd0;
      acc      <= '0;
      rowEmit  <= 1'b0;
      rowPhase <= 3'd0;
    end else begin
      if (sofHit) active <= 1'b1;
      widthReg <= widthNow;
      stepReg  <= stepNow;
      rowsReg  <= rowsNow;
      rowIdx   <= nextRow;
      wp       <= wpNow;
      acc      <= accNext;
      rowEmit  <= emitNow;
      rowPhase <= phaseNow;
      if (inValid && (active || sofHit)) col <= act ? colNow + 1'b1 : colNow;
    end
  end

  AST_SOF_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSof) |=> (rowIdx == '0 && wp == 2'd0));  // R3
  AST_ROW_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSol && !inSof && active && rowIdx != '1) |=> (rowIdx == $past(rowIdx) + 1'b1));  // R3
  AST_BANK_ROTATE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSol && !inSof && active) |=> (wp == (($past(wp) == 2'd2) ? 2'd0 : $past(wp) + 2'd1)));  // R4
  AST_COL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (col <= widthReg));  // R8
  AST_EMIT_AFTER_THREE: assert property (@(posedge clk) disable iff (!rstN)
    rowEmit |-> (rowIdx >= RW'(3)));  // R3

endmodule

// File: rtl/vpf_data.sv
module vpf_data
  import vpf_pkg::*;
#(
  parameter int DW   = 10,
  parameter int MAXW = 1280,
  localparam int AW   = $clog2(MAXW),
  localparam int ACCW = DW + COEF_W + 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  vpfStrobe_t           stb,
  input  logic [AW-1:0]        wrAddr,
  input  logic signed [DW-1:0] pixIn,
  output logic                 outValid,
  output logic signed [DW-1:0] outPix,
  output logic                 outEol,
  output logic                 outEof
);

  localparam logic signed [ACCW-1:0] SAT_HI = ACCW'((64'sd1 <<< (DW - 1)) - 64'sd1);
  localparam logic signed [ACCW-1:0] SAT_LO = ACCW'(-(64'sd1 <<< (DW - 1)));

  logic signed [DW-1:0] rdQ [NUM_BANKS];

  // one line store per bank: read the old word, then overwrite when this bank owns the row
  for (genvar g = 0; g < NUM_BANKS; g++) begin : gBank
    logic signed [DW-1:0] lineMem [MAXW];
    logic signed [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (stb.wrEn) begin
        q <= lineMem[wrAddr];
        if (stb.bank == 2'(g)) lineMem[wrAddr] <= pixIn;
      end
    end
    assign rdQ[g] = q;
  end

  logic                 s1Valid, s1Eol, s1Eof;
  logic [2:0]           s1Phase;
  logic [1:0]           s1Bank;
  logic signed [DW-1:0] s1Cur;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Eol   <= 1'b0;
      s1Eof   <= 1'b0;
      s1Phase <= 3'd0;
      s1Bank  <= 2'd0;
      s1Cur   <= '0;
    end else begin
      s1Valid <= stb.emit;
      s1Eol   <= stb.emit && stb.eol;
      s1Eof   <= stb.emit && stb.eof;
      s1Phase <= stb.phase;
      s1Bank  <= stb.bank;
      s1Cur   <= pixIn;
    end
  end

  logic signed [DW-1:0]   tapOld, tapMid, tapNew;
  logic signed [ACCW-1:0] sum, scaled, clipped;

  always_comb begin
    case (s1Bank)
      2'd0:    begin tapOld = rdQ[0]; tapMid = rdQ[1]; tapNew = rdQ[2]; end
      2'd1:    begin tapOld = rdQ[1]; tapMid = rdQ[2]; tapNew = rdQ[0]; end
      default: begin tapOld = rdQ[2]; tapMid = rdQ[0]; tapNew = rdQ[1]; end
    endcase
    sum = ACCW'(tapCoef(s1Phase, 0)) * ACCW'(tapOld)
        + ACCW'(tapCoef(s1Phase, 1)) * ACCW'(tapMid)
        + ACCW'(tapCoef(s1Phase, 2)) * ACCW'(tapNew)
        + ACCW'(tapCoef(s1Phase, 3)) * ACCW'(s1Cur);
    scaled = sum >>> COEF_SHIFT;
    if (scaled > SAT_HI)      clipped = SAT_HI;
    else if (scaled < SAT_LO) clipped = SAT_LO;
    else                      clipped = scaled;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outEol   <= 1'b0;
      outEof   <= 1'b0;
      outPix   <= '0;
    end else begin
      outValid <= s1Valid;
      outEol   <= s1Eol;
      outEof   <= s1Eof;
      outPix   <= clipped[DW-1:0];
    end
  end

  AST_PIPE_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(stb.emit, 2));  // R2
  AST_EOL_IS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    outEol |-> outValid);  // R9
  AST_EOF_ON_EOL: assert property (@(posedge clk) disable iff (!rstN)
    outEof |-> outEol);  // R9

endmodule

// File: rtl/vpf_vert_filter.sv
module vpf_vert_filter
  import vpf_pkg::*;
#(
  parameter int DW     = 10,
  parameter int MAXW   = 1280,
  parameter int RW     = 11,
  parameter int STEP_W = 6,
  localparam int AW = $clog2(MAXW),
  localparam int WW = $clog2(MAXW + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic                 inSof,
  input  logic                 inSol,
  input  logic signed [DW-1:0] inPix,
  input  logic [WW-1:0]        cfgWidth,
  input  logic [STEP_W-1:0]    cfgStep,
  input  logic [2:0]           cfgStartPhase,
  input  logic [RW-1:0]        cfgRows,
  output logic                 outValid,
  output logic signed [DW-1:0] outPix,
  output logic                 outEol,
  output logic                 outEof
);

  vpfStrobe_t    stb;
  logic [AW-1:0] wrAddr;

  vpf_ctrl #(.MAXW(MAXW), .RW(RW), .STEP_W(STEP_W)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inSol(inSol),
    .cfgWidth(cfgWidth), .cfgStep(cfgStep), .cfgStartPhase(cfgStartPhase),
    .cfgRows(cfgRows), .stb(stb), .wrAddr(wrAddr)
  );

  vpf_data #(.DW(DW), .MAXW(MAXW)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .wrAddr(wrAddr), .pixIn(inPix),
    .outValid(outValid), .outPix(outPix), .outEol(outEol), .outEof(outEof)
  );

endmodule

// File: tb/sim_vpf_vert_filter.sv
`timescale 1ns/1ps
module sim_vpf_vert_filter;

  logic              clk = 1'b0;
  logic              rstN;
  logic              inValid, inSof, inSol;
  logic signed [9:0] inPix;
  logic [10:0]       cfgWidth;
  logic [5:0]        cfgStep;
  logic [2:0]        cfgStartPhase;
  logic [10:0]       cfgRows;
  logic              outValid, outEol, outEof;
  logic signed [9:0] outPix;

  int    cyc = 0;
  int    nChecks = 0;
  int    nFails = 0;
  bit    done = 0;
  string curTag = "R3";

  int expCyc[$];
  int expVal[$];
  bit expEol[$];
  bit expEof[$];

  vpf_vert_filter u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inSol(inSol), .inPix(inPix),
    .cfgWidth(cfgWidth), .cfgStep(cfgStep), .cfgStartPhase(cfgStartPhase), .cfgRows(cfgRows),
    .outValid(outValid), .outPix(outPix), .outEol(outEol), .outEof(outEof)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pixVal(input int seed, input int r, input int c, input int mode);
    int h;
    if (mode == 1) return ((r + c) % 2 == 1) ? 511 : -512;
    h = seed * 1103515245 + r * 12345 + c * 747796405 + 17;
    h = h ^ (h >>> 13);
    h = h * 1664525;
    return ((h >>> 9) & 1023) - 512;
  endfunction

  function automatic int filtRef(input int seed, input int r, input int c, input int ph, input int mode);
    int s, y;
    s = -4 * pixVal(seed, r - 3, c, mode) + (72 - 8 * ph) * pixVal(seed, r - 2, c, mode)
      + 8 * ph * pixVal(seed, r - 1, c, mode) - 4 * pixVal(seed, r, c, mode);
    y = s >>> 6;
    if (y > 511) y = 511;
    if (y < -512) y = -512;
    return y;
  endfunction

  // output monitor: one queue entry per valid output, due at a fixed cycle
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expCyc.size() == 0) begin
        chk(1'b0, curTag, 1, 0);
      end else begin
        int ec, ev;
        bit el, ef;
        ec = expCyc.pop_front();
        ev = expVal.pop_front();
        el = expEol.pop_front();
        ef = expEof.pop_front();
        chk(cyc == ec, "R2", cyc, ec);
        chk(int'(outPix) == ev, curTag, int'(outPix), ev);
        chk(outEol == el, "R9", int'(outEol), int'(el));
        chk(outEof == ef, "R9", int'(outEof), int'(ef));
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0; inSof = 1'b0; inSol = 1'b0;
    end
  endtask

  task automatic sendFrame(input int w, input int st, input int sp, input int nr, input int extra,
                           input int mode, input int seed, input int gapPct, input bit scramble);
    int effW, effSt, acc, ph;
    bit emit;
    effW  = (w == 0 || w > 1280) ? 1280 : w;
    effSt = (st < 8) ? 8 : st;
    acc   = sp;
    for (int r = 0; r < nr; r++) begin
      emit = 1'b0; ph = 0;
      if (r >= 3) begin
        if (acc < 8) begin emit = 1'b1; ph = acc; acc = acc + effSt - 8; end
        else acc = acc - 8;
      end
      for (int c = 0; c < effW + extra; c++) begin
        if (gapPct > 0 && ($urandom % 100) < gapPct) idle(1 + $urandom % 2);
        @(negedge clk);
        if (r == 0 && c == 0) begin
          cfgWidth = 11'(w); cfgStep = 6'(st); cfgStartPhase = 3'(sp); cfgRows = 11'(nr);
        end else if (scramble) begin
          cfgWidth = 11'($urandom % 2048); cfgStep = 6'($urandom); cfgStartPhase = 3'($urandom);
          cfgRows = 11'($urandom);
        end
        inValid = 1'b1;
        inSof   = (r == 0 && c == 0);
        inSol   = (c == 0);
        inPix   = 10'(pixVal(seed, r, c, mode));
        if (emit && c < effW) begin
          expCyc.push_back(cyc + 2);
          expVal.push_back(filtRef(seed, r, c, ph, mode));
          expEol.push_back(c == effW - 1);
          expEof.push_back(c == effW - 1 && r == nr - 1);
        end
      end
    end
    idle(4);
    chk(expCyc.size() == 0, "R3", expCyc.size(), 0);
    expCyc.delete(); expVal.delete(); expEol.delete(); expEof.delete();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rstN = 1'b0; inValid = 1'b0; inSof = 1'b0; inSol = 1'b0; inPix = '0;
    cfgWidth = 11'd8; cfgStep = 6'd8; cfgStartPhase = 3'd0; cfgRows = 11'd8;
    repeat (3) @(negedge clk);
    chk(!outValid && !outEol && !outEof, "R1", int'(outValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!outValid && !outEol && !outEof, "R1", int'(outValid), 0);

    // R3: pixels before any start of frame are ignored
    curTag = "R3";
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      inValid = 1'b1; inSof = 1'b0; inSol = (i % 4 == 0); inPix = 10'(i * 37);
    end
    idle(4);

    curTag = "R4";
    sendFrame(6, 8, 0, 6, 0, 0, 1, 0, 1'b0);
    sendFrame(9, 8, 5, 7, 0, 0, 2, 0, 1'b0);
    curTag = "R5";
    sendFrame(8, 8, 0, 6, 0, 1, 3, 0, 1'b0);
    sendFrame(5, 8, 7, 6, 0, 1, 3, 0, 1'b0);
    curTag = "R6";
    sendFrame(7, 12, 3, 12, 0, 0, 4, 0, 1'b0);
    sendFrame(5, 20, 0, 14, 0, 0, 5, 0, 1'b0);
    sendFrame(4, 32, 6, 14, 0, 0, 6, 0, 1'b0);
    curTag = "R7";
    sendFrame(6, 3, 2, 8, 0, 0, 7, 0, 1'b0);
    curTag = "R8";
    sendFrame(5, 8, 1, 6, 4, 0, 8, 0, 1'b0);
    sendFrame(1, 8, 4, 5, 2, 0, 9, 0, 1'b0);
    sendFrame(0, 8, 0, 5, 0, 0, 10, 0, 1'b0);
    sendFrame(1300, 8, 2, 4, 3, 0, 11, 0, 1'b0);
    curTag = "R10";
    sendFrame(6, 12, 1, 9, 0, 0, 12, 0, 1'b1);
    curTag = "R4";
    for (int f = 0; f < 25; f++) begin
      sendFrame(1 + int'($urandom % 40), int'($urandom % 33), int'($urandom % 8),
                1 + int'($urandom % 14), int'($urandom % 4), int'($urandom % 2),
                100 + f, 30, ($urandom % 4) == 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

endmodule